// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the register-level face of one PS/2 keyboard or mouse port. A host reaches it over a simple word-addressed request bus: each request carries a byte offset, a write flag and write data, and a read returns its data one clock later together with a valid pulse. Requests to offsets that decode to nothing raise an error pulse instead.

Bytes arriving from an upstream byte source enter through a valid/ready handshake and wait in a small receive queue. The host takes them one at a time by reading the data register. Each read that finds a byte waiting moves that byte into a held last-byte register and returns it. A status word reports whether a byte is waiting and the odd parity of the held byte. Bytes the host writes to the data register leave as a one-cycle transmit strobe with the data, tagged with the keyboard/mouse mode so downstream logic can route them. A single level interrupt combines a receive-waiting term, gated by a control bit, with a second control bit that forces the line high. The block also holds a clock-divisor value that is only stored and read back, and a read-only identification window.

Top module: `ps2_port_regs`

## Requirements
- R1: After reset the control and divisor registers read 0, the held byte is 0, the receive queue is empty, `rx_ready` is 1 and `irq` is 0.
- R2: A register is chosen by the byte offset shifted right by two, so the two lowest offset bits are ignored: word 0 is control (read/write), word 3 is clock divisor (read/write). Read data and `bus_rvalid` appear in the cycle after the request.
- R3: Reads in the offset range 0xFE0 to 0xFFF return the identification byte at entry (offset − 0xFE0) >> 2 of the list 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R4: The status register (word 1) reads bit 6 = 1, bit 4 = 1 when a received byte waits, and bit 2 = XOR of all bits of the held byte; bits 5, 3, 1, 0 and 7 read 0.
- R5: Reading the data register (word 2) while a byte waits returns the oldest waiting byte, makes it the held byte and removes it from the queue; with nothing waiting it returns the held byte again. Bytes come out in arrival order.
- R6: The receive queue holds 4 bytes; while it is full `rx_ready` is 0 and an offered byte is not taken.
- R7: `irq` is 1 exactly when (a byte waits and control bit 4 is 1) or control bit 3 is 1, and follows a control write or a queue change in the cycle after it.
- R8: The interrupt-status register (word 4) reads bit 0 = byte waiting and bit 1 = 1, other bits 0.
- R9: A write to word 2 gives a one-cycle `tx_strobe` in the next cycle, with `tx_data` equal to the written byte and `tx_mouse` equal to `mode_mouse` at the time of the write.
- R10: A read of any other offset returns 0 with `bus_err` pulsed; a write to words 1, 4, 5 and up, or to the identification window, pulses `bus_err` and changes no register and sends nothing.
- R11: When a byte is offered and the data register is read in the same cycle, the read returns the byte that was already waiting and the offered byte is taken if and only if `rx_ready` was 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_mouse | input | 1 | 1 selects mouse, 0 keyboard; tags each transmit |
| bus_req | input | 1 | Bus request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after a read |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_err | output | 1 | Bad-offset pulse, one cycle after the request |
| rx_valid | input | 1 | Upstream offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Queue can take a byte |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_data | output | 8 | Byte to transmit |
| tx_mouse | output | 1 | Mode tag for the transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
The two functions that can meet in one cycle are the arrival of a byte from the upstream source and the host read that pops the queue. The bench drives `rx_valid` in the very cycle of a data-register read, once with one byte waiting and once with the queue full. It judges the outcome by the byte returned, by later reads that show whether the offered byte was queued, and by the final empty read that repeats the last byte.

// File: rtl/ps2_port_pkg.sv
package ps2_port_pkg;

  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_STAT   = 1;
  localparam int unsigned IDX_DATA   = 2;
  localparam int unsigned IDX_CLKDIV = 3;
  localparam int unsigned IDX_IRQST  = 4;

  localparam int unsigned ID_BASE    = 'hFE0;

  localparam int unsigned STAT_TXEMPTY = 6;
  localparam int unsigned STAT_RXFULL  = 4;
  localparam int unsigned STAT_PARITY  = 2;

  localparam int unsigned CTRL_RXIE  = 4;
  localparam int unsigned CTRL_FORCE = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_DATA,
    SEL_CLKDIV,
    SEL_IRQST,
    SEL_ID
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrClkDiv;
    logic   sendTx;
    logic   popData;
    logic   rdStrobe;
    logic   badAcc;
    rdSel_e sel;
    logic [2:0] idIdx;
  } ctrlStrobe_t;

  function automatic logic [7:0] idByte(input logic [2:0] i);
    case (i)
      3'd0:    idByte = 8'h50;
      3'd1:    idByte = 8'h10;
      3'd2:    idByte = 8'h04;
      3'd3:    idByte = 8'h00;
      3'd4:    idByte = 8'h0D;
      3'd5:    idByte = 8'hF0;
      3'd6:    idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ps2_rx_fifo.sv
module ps2_rx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          notEmpty,
  output logic          full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    nextPtr = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && wrPtr == PW'(g)) mem[g] <= pushData;
      end
    end
  endgenerate

  assign head     = mem[rdPtr];
  assign notEmpty = (cnt != '0);
  assign full     = (cnt == CW'(DEPTH));
  assign count    = cnt;

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_full_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

endmodule

// File: rtl/ps2_port_ctrl.sv
module ps2_port_ctrl
  import ps2_port_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          busReq,
  input  logic          busWe,
  input  logic [AW-1:0] busAddr,
  output ctrlStrobe_t   strobes
);
  logic [AW-1:0] wordIdx;
  logic [AW-1:0] idOff;
  logic          inId;

  assign wordIdx = busAddr >> 2;
  assign idOff   = (busAddr - AW'(ID_BASE)) >> 2;
  assign inId    = (busAddr >= AW'(ID_BASE));

  always_comb begin
    strobes          = '0;
    strobes.sel      = SEL_NONE;
    strobes.idIdx    = idOff[2:0];
    if (busReq) begin
      strobes.rdStrobe = !busWe;
      if (inId) begin
        if (busWe) strobes.badAcc = 1'b1;
        else       strobes.sel    = SEL_ID;
      end else begin
        case (wordIdx)
          AW'(IDX_CTRL): begin
            if (busWe) strobes.wrCtrl = 1'b1;
            else       strobes.sel    = SEL_CTRL;
          end
          AW'(IDX_STAT): begin
            if (busWe) strobes.badAcc = 1'b1;
            else       strobes.sel    = SEL_STAT;
          end
          AW'(IDX_DATA): begin
            if (busWe) strobes.sendTx = 1'b1;
            else begin
              strobes.sel     = SEL_DATA;
              strobes.popData = 1'b1;
            end
          end
          AW'(IDX_CLKDIV): begin
            if (busWe) strobes.wrClkDiv = 1'b1;
            else       strobes.sel      = SEL_CLKDIV;
          end
          AW'(IDX_IRQST): begin
            if (busWe) strobes.badAcc = 1'b1;
            else       strobes.sel    = SEL_IRQST;
          end
          default: strobes.badAcc = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/ps2_port_dp.sv
module ps2_port_dp
  import ps2_port_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrlStrobe_t   strobes,
  input  logic [DW-1:0] busWdata,
  input  logic          modeMouse,
  input  logic          rxValid,
  input  logic [DW-1:0] rxData,
  output logic          rxReady,
  output logic [DW-1:0] busRdata,
  output logic          busRvalid,
  output logic          busErr,
  output logic          txStrobe,
  output logic [DW-1:0] txData,
  output logic          txMouse,
  output logic          irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] ctrlReg, clkDivReg, lastByte, head, rdNext;
  logic          pending, full, push, pop, parity;
  logic [CW-1:0] count;

  assign rxReady = !full;
  assign push    = rxValid && rxReady;
  assign pop     = strobes.popData && pending;

  ps2_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pushData (rxData),
    .pop      (pop),
    .head     (head),
    .notEmpty (pending),
    .full     (full),
    .count    (count)
  );

  assign parity = ^lastByte;

  always_comb begin
    rdNext = '0;
    case (strobes.sel)
      SEL_CTRL:   rdNext = ctrlReg;
      SEL_CLKDIV: rdNext = clkDivReg;
      SEL_DATA:   rdNext = pending ? head : lastByte;
      SEL_STAT: begin
        rdNext[STAT_TXEMPTY] = 1'b1;
        rdNext[STAT_RXFULL]  = pending;
        rdNext[STAT_PARITY]  = parity;
      end
      SEL_IRQST: begin
        rdNext[0] = pending;
        rdNext[1] = 1'b1;
      end
      SEL_ID:     rdNext = DW'(idByte(strobes.idIdx));
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlReg   <= '0;
      clkDivReg <= '0;
      lastByte  <= '0;
      busRdata  <= '0;
      busRvalid <= 1'b0;
      busErr    <= 1'b0;
      txStrobe  <= 1'b0;
      txData    <= '0;
      txMouse   <= 1'b0;
    end else begin
      if (strobes.wrCtrl)   ctrlReg   <= busWdata;
      if (strobes.wrClkDiv) clkDivReg <= busWdata;
      if (pop)              lastByte  <= head;
      busRdata  <= strobes.rdStrobe ? rdNext : '0;
      busRvalid <= strobes.rdStrobe;
      busErr    <= strobes.badAcc;
      txStrobe  <= strobes.sendTx;
      if (strobes.sendTx) begin
        txData  <= busWdata;
        txMouse <= modeMouse;
      end
    end
  end

  assign irq = (pending && ctrlReg[CTRL_RXIE]) || ctrlReg[CTRL_FORCE];

  p_tx_follows_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.sendTx |=> (txStrobe && txData == $past(busWdata)));

  p_err_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busErr |-> (busRdata == '0));

  p_last_pop_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count == CW'(1)) |=> !pending);

  p_pop_keeps_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (lastByte == $past(head)));

endmodule

// File: rtl/ps2_port_regs.sv
module ps2_port_regs
  import ps2_port_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_mouse,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_mouse,
  output logic              irq
);
  ctrlStrobe_t strobes;

  ps2_port_ctrl #(.AW(ADDR_W)) u_ctrl (
    .busReq  (bus_req),
    .busWe   (bus_we),
    .busAddr (bus_addr),
    .strobes (strobes)
  );

  ps2_port_dp #(.DW(DATA_W), .DEPTH(RX_DEPTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .busWdata  (bus_wdata),
    .modeMouse (mode_mouse),
    .rxValid   (rx_valid),
    .rxData    (rx_data),
    .rxReady   (rx_ready),
    .busRdata  (bus_rdata),
    .busRvalid (bus_rvalid),
    .busErr    (bus_err),
    .txStrobe  (tx_strobe),
    .txData    (tx_data),
    .txMouse   (tx_mouse),
    .irq       (irq)
  );

  p_rvalid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_we));

endmodule

// File: tb/ps2_port_regs_tb.sv
`timescale 1ns/1ps
module ps2_port_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_mouse = 1'b0;
  logic       bus_req = 1'b0;
  logic       bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid, bus_err;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_strobe, tx_mouse, irq;
  logic [7:0] tx_data;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ps2_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .mode_mouse(mode_mouse),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_err(bus_err), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_data(tx_data),
    .tx_mouse(tx_mouse), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one bus/receive cycle: drive at negedge, sample at the following negedge
  task automatic cyc(input bit req, input bit we, input int addr, input int wd,
                     input bit rxv, input int rxd,
                     output logic [7:0] rd, output logic rv, output logic er);
    @(negedge clk);
    bus_req = req; bus_we = we; bus_addr = 12'(addr); bus_wdata = 8'(wd);
    rx_valid = rxv; rx_data = 8'(rxd);
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; rx_valid = 1'b0;
    rd = bus_rdata; rv = bus_rvalid; er = bus_err;
  endtask

  task automatic rd(input int addr, output logic [7:0] d, output logic er);
    logic rv;
    cyc(1, 0, addr, 0, 0, 0, d, rv, er);
    chk("R2 rvalid", int'(rv), 1);
  endtask

  task automatic wr(input int addr, input int val, output logic er);
    logic [7:0] d; logic rv;
    cyc(1, 1, addr, val, 0, 0, d, rv, er);
  endtask

  task automatic push(input int b);
    logic [7:0] d; logic rv, er;
    cyc(0, 0, 0, 0, 1, b, d, rv, er);
  endtask

  task automatic rdChk(input string tag, input int addr, input int exp);
    logic [7:0] d; logic er;
    rd(addr, d, er);
    chk(tag, int'(d), exp);
    chk({tag, " no err"}, int'(er), 0);
  endtask

  task automatic t_reset();
    chk("R1 rx_ready", int'(rx_ready), 1);
    chk("R1 irq", int'(irq), 0);
    rdChk("R1 ctrl", 'h000, 'h00);
    rdChk("R1 clkdiv", 'h00C, 'h00);
    rdChk("R1 data empty", 'h008, 'h00);
    rdChk("R4 status idle", 'h004, 'h40);
  endtask

  task automatic t_regs();
    logic er;
    wr('h000, 'h24, er);
    chk("R2 ctrl write err", int'(er), 0);
    rdChk("R2 ctrl readback", 'h000, 'h24);
    rdChk("R2 low bits ignored", 'h003, 'h24);
    wr('h00E, 'h5A, er);
    rdChk("R2 clkdiv readback", 'h00C, 'h5A);
    wr('h000, 'h00, er);
  endtask

  task automatic t_id();
    int tbl[8] = '{'h50, 'h10, 'h04, 'h00, 'h0D, 'hF0, 'h05, 'hB1};
    for (int i = 0; i < 8; i++) rdChk("R3 id", 'hFE0 + 4 * i, tbl[i]);
    rdChk("R3 id upper byte lane", 'hFFF, 'hB1);
  endtask

  task automatic t_fifo();
    push('h07); push('h03); push('h81); push('hFF);
    chk("R6 full ready low", int'(rx_ready), 0);
    push('h55);
    rdChk("R4 status pending", 'h004, 'h50);
    rdChk("R8 irqst pending", 'h010, 'h03);
    rdChk("R5 pop 1", 'h008, 'h07);
    chk("R6 ready after pop", int'(rx_ready), 1);
    rdChk("R4 parity odd", 'h004, 'h54);
    rdChk("R5 pop 2", 'h008, 'h03);
    rdChk("R4 parity even", 'h004, 'h50);
    rdChk("R5 pop 3", 'h008, 'h81);
    rdChk("R5 pop 4", 'h008, 'hFF);
    rdChk("R6 dropped byte absent", 'h008, 'hFF);
    rdChk("R8 irqst empty", 'h010, 'h02);
    rdChk("R4 status empty even", 'h004, 'h40);
  endtask

  task automatic t_irq();
    logic er;
    wr('h000, 'h10, er);
    chk("R7 gated no data", int'(irq), 0);
    push('h01);
    chk("R7 pending and enable", int'(irq), 1);
    rdChk("R5 pop for irq", 'h008, 'h01);
    chk("R7 drops after pop", int'(irq), 0);
    wr('h000, 'h08, er);
    chk("R7 force bit", int'(irq), 1);
    push('h02);
    wr('h000, 'h00, er);
    chk("R7 pending but disabled", int'(irq), 0);
    rdChk("R5 drain", 'h008, 'h02);
  endtask

  task automatic t_tx();
    logic er;
    mode_mouse = 1'b0;
    wr('h008, 'hA5, er);
    chk("R9 strobe", int'(tx_strobe), 1);
    chk("R9 data", int'(tx_data), 'hA5);
    chk("R9 keyboard tag", int'(tx_mouse), 0);
    @(negedge clk);
    chk("R9 one cycle", int'(tx_strobe), 0);
    mode_mouse = 1'b1;
    wr('h008, 'h3C, er);
    chk("R9 strobe mouse", int'(tx_strobe), 1);
    chk("R9 data mouse", int'(tx_data), 'h3C);
    chk("R9 mouse tag", int'(tx_mouse), 1);
    mode_mouse = 1'b0;
    wr('h000, 'h20, er);
    chk("R9 no strobe on ctrl write", int'(tx_strobe), 0);
  endtask

  task automatic t_bad();
    logic [7:0] d; logic er;
    rd('h014, d, er);
    chk("R10 read word5 data", int'(d), 0);
    chk("R10 read word5 err", int'(er), 1);
    rd('hF00, d, er);
    chk("R10 read hole err", int'(er), 1);
    chk("R10 read hole data", int'(d), 0);
    wr('h004, 'hFF, er);
    chk("R10 write status err", int'(er), 1);
    chk("R10 write status no tx", int'(tx_strobe), 0);
    wr('h010, 'hFF, er);
    chk("R10 write irqst err", int'(er), 1);
    wr('hFE0, 'h99, er);
    chk("R10 write id err", int'(er), 1);
    wr('h020, 'h77, er);
    chk("R10 write hole err", int'(er), 1);
    chk("R10 irq unchanged", int'(irq), 0);
    rdChk("R10 ctrl unchanged", 'h000, 'h20);
    rdChk("R10 clkdiv unchanged", 'h00C, 'h5A);
    rdChk("R10 id unchanged", 'hFE0, 'h50);
  endtask

  task automatic t_concurrent();
    logic [7:0] d; logic rv, er;
    push('h11);
    cyc(1, 0, 'h008, 0, 1, 'h22, d, rv, er);
    chk("R11 read returns waiting byte", int'(d), 'h11);
    rdChk("R11 offered byte queued", 'h008, 'h22);
    push('h31); push('h32); push('h33); push('h34);
    chk("R11 full before", int'(rx_ready), 0);
    cyc(1, 0, 'h008, 0, 1, 'h99, d, rv, er);
    chk("R11 read when full", int'(d), 'h31);
    rdChk("R11 order 2", 'h008, 'h32);
    rdChk("R11 order 3", 'h008, 'h33);
    rdChk("R11 order 4", 'h008, 'h34);
    rdChk("R11 refused byte absent", 'h008, 'h34);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_id();
    t_fifo();
    t_irq();
    t_tx();
    t_bad();
    t_concurrent();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule